// File: doc/BRIEF.md
# Inbound Address Window Translator

This block sits on the receive side of an address-routed request path. Each incoming request address is checked against a set of programmable inbound windows. A request with a 3DW header carries a 32-bit address, and a request with a 4DW header carries a 64-bit address. A match converts the address into a 36-bit internal bus address and reports which window matched. If no window matches, the request is marked as unsupported, and the logic further down the path turns that into an error completion.

Every window holds four settings:

- a 64-bit base;
- a 64-bit match mask, where a mask of all zeros turns the window off;
- a 32-bit translate value;
- a 4-bit upper translate value.

All of these are written and read through a plain register port with a single-cycle strobe. Lookups pass through one registered stage. There is a valid/ready handshake on both the input and the output, so the stage can take a new request on every cycle for as long as the consumer keeps accepting.

Top module: `ib_win_xlate`

## Requirements
- R1: With `in_is4dw` low, bits 63:32 of `in_addr` are ignored and the address is treated as `{32'h0, in_addr[31:0]}`. With `in_is4dw` high, all 64 bits are used.
- R2: Window w matches when `(A & mask_w) == (base_w & mask_w)` over all 64 bits of the effective address A. Upper address bits therefore take part in the decode.
- R3: A window whose 64-bit mask is zero never matches, whatever its base is.
- R4: When several windows match, the one with the lowest index is reported on `out_win`.
- R5: On a hit, `out_addr = {upper_w[3:0], (A[31:0] & ~mask_w[31:0]) | (xlat_w & mask_w[31:0])}`.
- R6: On a miss, `out_ur` is 1, `out_hit` is 0, and both `out_addr` and `out_win` are 0. On a hit, `out_ur` is 0 and `out_hit` is 1.
- R7: The input is accepted when `in_valid && in_ready`. The condition `in_ready = !out_valid || out_ready` holds. An accepted request appears on the output on the next cycle. While `out_valid && !out_ready`, the output fields hold steady.
- R8: The register address is `reg_addr = {window index, field[2:0]}`, and a write happens at the clock edge where `reg_wr` is high. The field codes are:
  - 0: base bits 31:0
  - 1: base bits 63:32
  - 2: mask bits 31:0
  - 3: mask bits 63:32
  - 4: translate value
  - 5: upper translate value (bits 3:0 only)
- R8 (continued): `reg_rdata` shows the addressed field combinationally, with the upper translate value zero-extended. Field codes 6 and 7 read as zero, and writes to them change nothing.
- R9: After reset, `out_valid` is 0 and every window register reads 0, which leaves every window disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | IDX_W+3 | Window index and field code |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| in_valid | input | 1 | Request address valid |
| in_ready | output | 1 | Stage can take a request |
| in_is4dw | input | 1 | 1 = 64-bit address, 0 = 32-bit address |
| in_addr | input | 64 | Request address |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_hit | output | 1 | A window matched |
| out_ur | output | 1 | Unsupported request (no window matched) |
| out_win | output | IDX_W | Index of the matching window |
| out_addr | output | 36 | Translated internal bus address |

## Verification
The bench builds the block with the default of four windows. Four windows are enough to set up the following cases:

- two nested windows, so that priority can be tested;
- a third window that is disabled with an all-zero mask and would otherwise match every address;
- a window that is only reachable with a non-zero upper 32-bit address.

The bench also re-programs windows in the middle of the run. Re-enabling a window and clearing the mask of the higher-priority window change which window wins. During a phase with random output backpressure, requests arrive back to back. This covers holding and draining the result register together with 3DW aliasing and misses in the upper address bits.

// File: rtl/ibw_pkg.sv
package ibw_pkg;
  localparam int EXT_AW = 64;
  localparam int LOW_AW = 32;
  localparam int INT_AW = 36;
  localparam int UP_W   = INT_AW - LOW_AW;
  localparam int REG_DW = 32;
  localparam int FLD_W  = 3;

  typedef enum logic [FLD_W-1:0] {
    FLD_BASE_LO = 3'd0,
    FLD_BASE_HI = 3'd1,
    FLD_MASK_LO = 3'd2,
    FLD_MASK_HI = 3'd3,
    FLD_XLAT    = 3'd4,
    FLD_UPPER   = 3'd5
  } ibw_field_e;

  typedef struct packed {
    logic [EXT_AW-1:0] base;
    logic [EXT_AW-1:0] mask;
    logic [LOW_AW-1:0] xlat;
    logic [UP_W-1:0]   upper;
  } win_cfg_t;
endpackage

// File: rtl/ibw_regfile.sv
module ibw_regfile
  import ibw_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int IDX_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  win_sel,
  input  logic [FLD_W-1:0]  fld_sel,
  input  logic [REG_DW-1:0] wr_data,
  output logic [REG_DW-1:0] rd_data,
  output win_cfg_t          cfg [NUM_WIN]
);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    win_cfg_t cur_q;
    win_cfg_t nxt;
    logic     sel;

    assign sel = wr_en && (win_sel == IDX_W'(w));

    always_comb begin
      nxt = cur_q;
      case (fld_sel)
        FLD_BASE_LO: nxt.base[LOW_AW-1:0]      = wr_data;
        FLD_BASE_HI: nxt.base[EXT_AW-1:LOW_AW] = wr_data;
        FLD_MASK_LO: nxt.mask[LOW_AW-1:0]      = wr_data;
        FLD_MASK_HI: nxt.mask[EXT_AW-1:LOW_AW] = wr_data;
        FLD_XLAT:    nxt.xlat                  = wr_data;
        FLD_UPPER:   nxt.upper                 = wr_data[UP_W-1:0];
        default:     nxt                       = cur_q;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur_q <= '0;
      end else if (sel) begin
        cur_q <= nxt;
      end
    end

    assign cfg[w] = cur_q;
  end

  always_comb begin
    rd_data = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (win_sel == IDX_W'(w)) begin
        case (fld_sel)
          FLD_BASE_LO: rd_data = cfg[w].base[LOW_AW-1:0];
          FLD_BASE_HI: rd_data = cfg[w].base[EXT_AW-1:LOW_AW];
          FLD_MASK_LO: rd_data = cfg[w].mask[LOW_AW-1:0];
          FLD_MASK_HI: rd_data = cfg[w].mask[EXT_AW-1:LOW_AW];
          FLD_XLAT:    rd_data = cfg[w].xlat;
          FLD_UPPER:   rd_data = REG_DW'(cfg[w].upper);
          default:     rd_data = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ibw_match.sv
module ibw_match
  import ibw_pkg::*;
#(
  parameter int NUM_WIN = 4
) (
  input  logic [EXT_AW-1:0]  ext_addr,
  input  win_cfg_t           cfg [NUM_WIN],
  output logic [NUM_WIN-1:0] hit_vec
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    logic enabled;
    logic agree;
    assign enabled    = |cfg[w].mask;
    assign agree      = ~|((ext_addr ^ cfg[w].base) & cfg[w].mask);
    assign hit_vec[w] = enabled && agree;
  end
endmodule

// File: rtl/ibw_select.sv
module ibw_select
  import ibw_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int IDX_W   = 2
) (
  input  logic [NUM_WIN-1:0] hit_vec,
  input  win_cfg_t           cfg [NUM_WIN],
  input  logic [LOW_AW-1:0]  low_addr,
  output logic               any_hit,
  output logic [IDX_W-1:0]   win_idx,
  output logic [INT_AW-1:0]  xaddr
);
  always_comb begin
    any_hit = 1'b0;
    win_idx = '0;
    xaddr   = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hit_vec[w]) begin
        any_hit = 1'b1;
        win_idx = IDX_W'(w);
        xaddr   = {cfg[w].upper,
                   (low_addr & ~cfg[w].mask[LOW_AW-1:0]) |
                   (cfg[w].xlat & cfg[w].mask[LOW_AW-1:0])};
      end
    end
  end
endmodule

// File: rtl/ib_win_xlate.sv
module ib_win_xlate
  import ibw_pkg::*;
#(
  parameter  int NUM_WIN = 4,
  localparam int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int REG_AW  = IDX_W + FLD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_is4dw,
  input  logic [EXT_AW-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_hit,
  output logic              out_ur,
  output logic [IDX_W-1:0]  out_win,
  output logic [INT_AW-1:0] out_addr
);

  win_cfg_t            cfg [NUM_WIN];
  logic [EXT_AW-1:0]   ext_addr;
  logic [NUM_WIN-1:0]  hit_vec;
  logic                any_hit;
  logic [IDX_W-1:0]    win_idx;
  logic [INT_AW-1:0]   xaddr;
  logic                accept;

  logic                valid_q, valid_d;
  logic                hit_q, hit_d;
  logic                ur_q, ur_d;
  logic [IDX_W-1:0]    win_q, win_d;
  logic [INT_AW-1:0]   addr_q, addr_d;

  ibw_regfile #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .win_sel (reg_addr[REG_AW-1:FLD_W]),
    .fld_sel (reg_addr[FLD_W-1:0]),
    .wr_data (reg_wdata),
    .rd_data (reg_rdata),
    .cfg     (cfg)
  );

  assign ext_addr = in_is4dw ? in_addr : {{(EXT_AW-LOW_AW){1'b0}}, in_addr[LOW_AW-1:0]};

  ibw_match #(.NUM_WIN(NUM_WIN)) u_match (
    .ext_addr (ext_addr),
    .cfg      (cfg),
    .hit_vec  (hit_vec)
  );

  ibw_select #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_sel (
    .hit_vec  (hit_vec),
    .cfg      (cfg),
    .low_addr (ext_addr[LOW_AW-1:0]),
    .any_hit  (any_hit),
    .win_idx  (win_idx),
    .xaddr    (xaddr)
  );

  assign in_ready = !valid_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_comb begin
    valid_d = in_ready ? in_valid : valid_q;
    hit_d   = any_hit;
    ur_d    = !any_hit;
    win_d   = win_idx;
    addr_d  = xaddr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else if (in_ready) begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      ur_q   <= 1'b0;
      win_q  <= '0;
      addr_q <= '0;
    end else if (accept) begin
      hit_q  <= hit_d;
      ur_q   <= ur_d;
      win_q  <= win_d;
      addr_q <= addr_d;
    end
  end

  assign out_valid = valid_q;
  assign out_hit   = hit_q;
  assign out_ur    = ur_q;
  assign out_win   = win_q;
  assign out_addr  = addr_q;
endmodule

// File: rtl/ibw_checker.sv
module ibw_checker #(
  parameter int NUM_WIN = 4,
  parameter int IDX_W   = 2,
  parameter int INT_AW  = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_hit,
  input logic              out_ur,
  input logic [IDX_W-1:0]  out_win,
  input logic [INT_AW-1:0] out_addr
);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_win)
                                && $stable(out_hit) && $stable(out_ur));

  assert_backpressure_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  assert_hit_xor_ur_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_hit ^ out_ur));

  assert_miss_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ur |-> (out_addr == '0) && (out_win == '0));

  assert_win_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_hit |-> (32'(out_win) < NUM_WIN));
endmodule

bind ib_win_xlate ibw_checker #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W), .INT_AW(ibw_pkg::INT_AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_hit   (out_hit),
  .out_ur    (out_ur),
  .out_win   (out_win),
  .out_addr  (out_addr)
);

// File: tb/ib_win_xlate_test.sv
module ib_win_xlate_test;
  localparam int NW = 4;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        in_valid;
  logic        in_ready;
  logic        in_is4dw;
  logic [63:0] in_addr;
  logic        out_valid;
  logic        out_ready;
  logic        out_hit;
  logic        out_ur;
  logic [1:0]  out_win;
  logic [35:0] out_addr;

  ib_win_xlate #(.NUM_WIN(NW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
    .in_ready(in_ready), .in_is4dw(in_is4dw), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_hit(out_hit),
    .out_ur(out_ur), .out_win(out_win), .out_addr(out_addr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int    n_cmp = 0;
  int    n_bad = 0;
  string phase = "R9 reset";
  bit    stall_en = 0;
  bit    done = 0;

  // behavioural reference state
  logic [63:0] m_base [NW];
  logic [63:0] m_mask [NW];
  logic [31:0] m_xlat [NW];
  logic [3:0]  m_up   [NW];
  logic        m_valid, m_hit, m_ur;
  logic [1:0]  m_win;
  logic [35:0] m_addr;

  function automatic logic [31:0] m_read(input logic [4:0] a);
    int w = int'(a[4:3]);
    case (a[2:0])
      3'd0: return m_base[w][31:0];
      3'd1: return m_base[w][63:32];
      3'd2: return m_mask[w][31:0];
      3'd3: return m_mask[w][63:32];
      3'd4: return m_xlat[w];
      3'd5: return {28'h0, m_up[w]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic m_lookup(input logic is4, input logic [63:0] a);
    logic [63:0] ea;
    ea = is4 ? a : {32'h0, a[31:0]};
    m_hit = 0; m_ur = 1; m_win = 0; m_addr = 0;
    for (int w = 0; w < NW; w++) begin
      if (!m_hit && m_mask[w] != 0 && (ea & m_mask[w]) == (m_base[w] & m_mask[w])) begin
        m_hit = 1; m_ur = 0; m_win = 2'(w);
        m_addr = {m_up[w], (ea[31:0] & ~m_mask[w][31:0]) | (m_xlat[w] & m_mask[w][31:0])};
      end
    end
  endtask

  task automatic model_step();
    if (!rst_n) begin
      m_valid = 0; m_hit = 0; m_ur = 0; m_win = 0; m_addr = 0;
      for (int w = 0; w < NW; w++) begin
        m_base[w] = 0; m_mask[w] = 0; m_xlat[w] = 0; m_up[w] = 0;
      end
    end else begin
      if (!m_valid || out_ready) begin
        m_valid = in_valid;
        if (in_valid) m_lookup(in_is4dw, in_addr);
      end
      if (reg_wr) begin
        int w = int'(reg_addr[4:3]);
        case (reg_addr[2:0])
          3'd0: m_base[w][31:0]  = reg_wdata;
          3'd1: m_base[w][63:32] = reg_wdata;
          3'd2: m_mask[w][31:0]  = reg_wdata;
          3'd3: m_mask[w][63:32] = reg_wdata;
          3'd4: m_xlat[w]        = reg_wdata;
          3'd5: m_up[w]          = reg_wdata[3:0];
          default: ;
        endcase
      end
    end
  endtask

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL [%s] %s: actual %h expected %h", phase, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    model_step();
    #3;
    if (!done) begin
      chk("R7 out_valid", 64'(out_valid), 64'(m_valid));
      chk("R7 in_ready", 64'(in_ready), 64'(!m_valid || out_ready));
      if (m_valid) begin
        chk("R2 out_hit", 64'(out_hit), 64'(m_hit));
        chk("R6 out_ur", 64'(out_ur), 64'(m_ur));
        chk("R4 out_win", 64'(out_win), 64'(m_win));
        chk("R5 out_addr", 64'(out_addr), 64'(m_addr));
      end
      chk("R8 reg_rdata", 64'(reg_rdata), 64'(m_read(reg_addr)));
    end
  end

  always @(negedge clk) out_ready = stall_en ? 1'($random) : 1'b1;

  task automatic wr(input int w, input int f, input logic [31:0] d);
    reg_wr = 1; reg_addr = {2'(w), 3'(f)}; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic wr_win(input int w, input logic [63:0] b, input logic [63:0] m,
                        input logic [31:0] x, input logic [3:0] u);
    wr(w, 0, b[31:0]); wr(w, 1, b[63:32]);
    wr(w, 2, m[31:0]); wr(w, 3, m[63:32]);
    wr(w, 4, x);       wr(w, 5, {28'hABCDEF0, u});
  endtask

  task automatic send(input logic is4, input logic [63:0] a);
    bit took = 0;
    in_valid = 1; in_is4dw = is4; in_addr = a;
    while (!took) begin
      #1 took = in_ready;
      @(negedge clk);
    end
    in_valid = 0;
  endtask

  task automatic report();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL [watchdog] run hung: actual running expected finished");
    report();
  end

  initial begin
    rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    in_valid = 0; in_is4dw = 0; in_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9: registers read back zero after reset
    for (int a = 0; a < 32; a++) begin reg_addr = 5'(a); @(negedge clk); end

    phase = "R8 regs";
    wr_win(0, 64'h0000_0001_8000_0000, 64'hFFFF_FFFF_F000_0000, 32'h2000_0000, 4'h3);
    wr_win(1, 64'h0000_0000_4000_0000, 64'hFFFF_FFFF_FFF0_0000, 32'h0010_0000, 4'h5);
    wr_win(2, 64'h0000_0000_4000_0000, 64'hFFFF_FFFF_FF00_0000, 32'h0A00_0000, 4'h9);
    wr(3, 0, 32'h0); wr(3, 1, 32'h0); wr(3, 4, 32'hFFFF_F000); wr(3, 5, 32'hF);
    wr(1, 6, 32'hFFFF_FFFF); wr(2, 7, 32'h1234_5678);   // R8 unused codes ignored
    for (int a = 0; a < 32; a++) begin reg_addr = 5'(a); @(negedge clk); end

    phase = "R1 3dw";
    send(0, 64'hDEAD_BEEF_4001_2345);
    send(0, 64'hFFFF_FFFF_8123_4567);
    phase = "R2 4dw";
    send(1, 64'hDEAD_BEEF_4001_2345);
    send(1, 64'h0000_0001_8123_4567);
    send(1, 64'h0000_0002_8123_4567);
    phase = "R4 priority";
    send(1, 64'h0000_0000_4000_0010);
    send(0, 64'h0000_0000_4080_0000);
    phase = "R3 disabled";
    send(1, 64'h0000_0000_0000_0100);
    send(0, 64'h1234_0000_7777_0000);
    phase = "R5 xlate";
    wr(3, 2, 32'hFFFF_F000); wr(3, 3, 32'hFFFF_FFFF);
    send(0, 64'h0000_0000_0000_0ABC);
    send(1, 64'h0000_0000_0000_1ABC);
    phase = "R3 disabled";
    wr(1, 2, 32'h0); wr(1, 3, 32'h0);
    send(1, 64'h0000_0000_4000_0010);
    phase = "R6 miss";
    send(1, 64'h8000_0000_4000_0010);
    send(0, 64'h0000_0000_C000_0000);

    phase = "R7 stall";
    stall_en = 1;
    for (int i = 0; i < 300; i++) begin
      logic [63:0] a;
      case ($unsigned($random) % 5)
        0: a = 64'h0000_0001_8000_0000 | 64'($unsigned($random) & 32'h0FFF_FFFF);
        1: a = 64'h0000_0000_4000_0000 | 64'($unsigned($random) & 32'h00FF_FFFF);
        2: a = 64'($unsigned($random) & 32'h0000_0FFF);
        3: a = {32'($random), 32'($random)};
        default: a = {32'h0, 32'($random)};
      endcase
      reg_addr = 5'($random);
      send(1'($random), a);
    end
    stall_en = 0;
    repeat (4) @(negedge clk);
    report();
  end
endmodule